// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Front End

This block is the serial side of a small byte-addressed EEPROM model holding 512 bytes. A host drives an SPI bus in mode 0 (clock idles low) or mode 3 (clock idles high). The block runs entirely on the chip's own clock. It brings the bus pins into that domain through synchronizers and detects the SCK edges itself. Every field on the bus moves most significant bit first. Each chip-select frame opens with an opcode byte. For the two array commands, that opcode also carries the ninth address bit. The following byte supplies the low eight address bits.

For an array read, the block fetches bytes from a synchronous memory port and streams them out on SO. The address advances by one per byte and wraps from the last location back to zero. For an array write, each received data byte goes to a separate write unit, together with an address whose three low bits wrap inside an 8-byte page. A commit strobe is raised when chip select closes cleanly. The block also provides the following:

- Set and clear strobes for the write-enable latch.
- A status stream on SO, fed from the write/protection unit's status byte.
- A status-byte write strobe.
- A pause function: the hold input freezes the serial sequence without resetting it.
- Rejection of unknown opcodes.
- Rejection of every command except the status read while the write unit reports a busy programming cycle.

Top module: `spi_ee_slave`

## Requirements
- R1: While reset is applied, and whenever chip select (`spi_cs_n`, active low) has been high for a few clocks, `spi_so_oe` is 0 and no strobe output is active.
- R2: Bits are sampled on rising SCK, MSB first. Opcode 0x03 is an array read: the next byte is A7..A0, and the byte at that address is then driven on `spi_so`, MSB first. Each bit changes after a falling SCK, so it is valid at the host's next rising edge. `spi_so_oe` is 1 while the data is driven.
- R3: Opcode bit 3 carries address bit A8 for reads and writes (0x0B reads from the upper half, 0x0A writes to it). During a read, SI is ignored after the address, and consecutive bytes come from consecutive addresses, with 0x1FF followed by 0x000.
- R4: An opcode byte that matches none of the listed encodings produces no strobe and leaves `spi_so_oe` at 0 for the rest of the frame. The next frame is decoded normally.
- R5: `spi_hold_n` low pauses the sequence. The pause takes effect, and is released, only while SCK is low. While paused, SCK edges are ignored, `spi_so_oe` is 0, and the bit position is kept, so the frame resumes where it stopped.
- R6: While `wr_busy` is 1 when an opcode completes, every opcode except the status read (0x05) is ignored: no strobe is raised and SO stays disabled.
- R7: Opcode 0x06 raises `cmd_wen_set` for one clock. Opcode 0x04 raises `cmd_wen_clr` for one clock.
- R8: Opcode 0x05 streams the `stat_in` byte on SO, repeatedly, for as long as the host keeps clocking; `stat_in` is captured again for each byte.
- R9: Opcode 0x01 takes the following byte and presents it on `sr_wr_data` with a one-clock `sr_wr_vld`.
- R10: Opcode 0x02 (or 0x0A) followed by an address byte turns each further byte into a one-clock `wr_byte_vld`, carrying `wr_data` and `wr_addr`. After each byte, address bits 2..0 increment modulo 8 and bits 8..3 stay fixed.
- R11: `wr_commit` pulses once when chip select rises after at least one write data byte, with the frame ending on a byte boundary. A rise in mid-byte aborts the frame without a commit, and the bit count restarts in the next frame.
- R12: Mode 3 (SCK high while idle and at chip-select edges) gives the same results as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO (0 = high impedance) |
| mem_rd_en | output | 1 | Array read request |
| mem_addr | output | 9 | Array read address |
| mem_rdata | input | 8 | Array data, valid one clock after the request |
| stat_in | input | 8 | Status byte from the write/protection unit |
| wr_busy | input | 1 | Programming cycle in progress |
| cmd_wen_set | output | 1 | Write-enable latch set strobe |
| cmd_wen_clr | output | 1 | Write-enable latch clear strobe |
| sr_wr_vld | output | 1 | Status byte write strobe |
| sr_wr_data | output | 8 | Status byte to write |
| wr_byte_vld | output | 1 | Write data byte strobe |
| wr_addr | output | 9 | Address of the write data byte |
| wr_data | output | 8 | Write data byte |
| wr_commit | output | 1 | Start-programming strobe at frame end |

## Verification
SCK edges reach the logic two clocks after they change on the pins. The eighth rising edge of a byte therefore raises its strobe or memory request about three clocks later, and a commit follows chip-select release after the same delay. A read byte is already buffered when the next falling SCK arrives, and that falling edge places its MSB on SO about three clocks later. The bench uses an SCK half period of eight clocks, so it samples SO at the host's rising edge, well after the bit has settled. It compares strobes at falling clock edges against queued expectations, and reads the strobe counters only after the frame has ended and settled.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_BIT = 3;

  localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OP_WR_DISABLE = 8'h04;
  localparam logic [7:0] OP_STAT_RD    = 8'h05;
  localparam logic [7:0] OP_STAT_WR    = 8'h01;
  localparam logic [7:0] OP_ARRAY_RD   = 8'h03;
  localparam logic [7:0] OP_ARRAY_WR   = 8'h02;
  localparam logic [7:0] HI_MASK       = ~(8'h01 << HI_BIT);

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_RDAT,
    ST_STAT,
    ST_WDAT,
    ST_SRDAT,
    ST_DEAD
  } fe_state_t;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_ee_link.sv
module spi_ee_link #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              si_s,
  input  logic              hold_n_s,
  output logic              sel_start,
  output logic              sel_end,
  output logic              sel_act,
  output logic              bit_fall,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              held
);
  logic              sck_q, cs_q, held_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-2:0] sh_q, sh_n;
  logic              held_n;
  logic              bit_rise;

  assign sel_start = cs_q & ~cs_n_s;
  assign sel_end   = ~cs_q & cs_n_s;
  assign sel_act   = ~cs_q & ~cs_n_s;
  assign bit_rise  = ~sck_q & sck_s & sel_act & ~held_q;
  assign bit_fall  = sck_q & ~sck_s & sel_act & ~held_q;
  assign byte_done = bit_rise & (cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte   = {sh_q, si_s};
  assign bit_cnt   = cnt_q;
  assign held      = held_q;

  always_comb begin
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    held_n = held_q;
    if (!sel_act) begin
      cnt_n  = '0;
      held_n = 1'b0;
    end else begin
      if (!sck_s) begin
        held_n = ~hold_n_s;
      end
      if (bit_rise) begin
        cnt_n = cnt_q + CNT_W'(1);
        sh_n  = {sh_q[BYTE_W-3:0], si_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      held_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sck_q  <= sck_s;
      cs_q   <= cs_n_s;
      held_q <= held_n;
      cnt_q  <= cnt_n;
      if (bit_rise) begin
        sh_q <= sh_n;
      end
    end
  end
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              wr_busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              load_stat,
  output logic              cmd_wen_set,
  output logic              cmd_wen_clr,
  output logic              sr_wr_vld,
  output logic [BYTE_W-1:0] sr_wr_data,
  output logic              wr_byte_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  fe_state_t         st_q, st_n;
  logic              hi_q, hi_n;
  logic              wmode_q, wmode_n;
  logic              any_q, any_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ADDR_W-1:0] full_addr;
  logic [BYTE_W-1:0] op_base;

  assign full_addr  = ADDR_W'({hi_q, rx_byte});
  assign op_base    = rx_byte & HI_MASK;
  assign wr_addr    = addr_q;
  assign wr_data    = rx_byte;
  assign sr_wr_data = rx_byte;

  always_comb begin
    st_n        = st_q;
    hi_n        = hi_q;
    wmode_n     = wmode_q;
    any_n       = any_q;
    addr_n      = addr_q;
    mem_rd_en   = 1'b0;
    mem_addr    = addr_q;
    load_stat   = 1'b0;
    cmd_wen_set = 1'b0;
    cmd_wen_clr = 1'b0;
    sr_wr_vld   = 1'b0;
    wr_byte_vld = 1'b0;
    wr_commit   = 1'b0;
    if (sel_end) begin
      wr_commit = (st_q == ST_WDAT) && any_q && (bit_cnt == '0);
      st_n      = ST_OPC;
      any_n     = 1'b0;
    end else if (sel_start) begin
      st_n  = ST_OPC;
      any_n = 1'b0;
    end else if (byte_done) begin
      unique case (st_q)
        ST_OPC: begin
          if (wr_busy && (rx_byte != OP_STAT_RD)) begin
            st_n = ST_DEAD;
          end else if (rx_byte == OP_STAT_RD) begin
            load_stat = 1'b1;
            st_n      = ST_STAT;
          end else if (rx_byte == OP_WR_ENABLE) begin
            cmd_wen_set = 1'b1;
            st_n        = ST_DEAD;
          end else if (rx_byte == OP_WR_DISABLE) begin
            cmd_wen_clr = 1'b1;
            st_n        = ST_DEAD;
          end else if (rx_byte == OP_STAT_WR) begin
            st_n = ST_SRDAT;
          end else if (op_base == OP_ARRAY_RD) begin
            hi_n    = rx_byte[HI_BIT];
            wmode_n = 1'b0;
            st_n    = ST_ADDR;
          end else if (op_base == OP_ARRAY_WR) begin
            hi_n    = rx_byte[HI_BIT];
            wmode_n = 1'b1;
            st_n    = ST_ADDR;
          end else begin
            st_n = ST_DEAD;
          end
        end
        ST_ADDR: begin
          if (wmode_q) begin
            addr_n = full_addr;
            st_n   = ST_WDAT;
          end else begin
            mem_rd_en = 1'b1;
            mem_addr  = full_addr;
            addr_n    = full_addr + ADDR_W'(1);
            st_n      = ST_RDAT;
          end
        end
        ST_RDAT: begin
          mem_rd_en = 1'b1;
          addr_n    = addr_q + ADDR_W'(1);
        end
        ST_STAT: begin
          load_stat = 1'b1;
        end
        ST_WDAT: begin
          wr_byte_vld = 1'b1;
          any_n       = 1'b1;
          addr_n      = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
        end
        ST_SRDAT: begin
          sr_wr_vld = 1'b1;
          st_n      = ST_DEAD;
        end
        default: begin
          st_n = ST_DEAD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OPC;
      hi_q    <= 1'b0;
      wmode_q <= 1'b0;
      any_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      st_q    <= st_n;
      hi_q    <= hi_n;
      wmode_q <= wmode_n;
      any_q   <= any_n;
      addr_q  <= addr_n;
    end
  end
endmodule

// File: rtl/spi_ee_tx.sv
module spi_ee_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act,
  input  logic              held,
  input  logic              bit_fall,
  input  logic              load_mem,
  input  logic              load_stat,
  input  logic [BYTE_W-1:0] stat_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              so,
  output logic              so_oe
);
  logic              pend_q, pend_n;
  logic              full_q, full_n;
  logic              act_q, act_n;
  logic [BYTE_W-1:0] buf_q, buf_n;
  logic [BYTE_W-1:0] sh_q, sh_n;

  assign so    = sh_q[BYTE_W-1];
  assign so_oe = act_q & sel_act & ~held;

  always_comb begin
    pend_n = 1'b0;
    full_n = full_q;
    act_n  = act_q;
    buf_n  = buf_q;
    sh_n   = sh_q;
    if (!sel_act) begin
      full_n = 1'b0;
      act_n  = 1'b0;
    end else begin
      pend_n = load_mem;
      if (bit_fall) begin
        if (full_q) begin
          sh_n   = buf_q;
          full_n = 1'b0;
          act_n  = 1'b1;
        end else begin
          sh_n = {sh_q[BYTE_W-2:0], 1'b0};
        end
      end
      if (load_stat) begin
        buf_n  = stat_in;
        full_n = 1'b1;
      end
      if (pend_q) begin
        buf_n  = mem_rdata;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      full_q <= 1'b0;
      act_q  <= 1'b0;
      buf_q  <= '0;
      sh_q   <= '0;
    end else begin
      pend_q <= pend_n;
      full_q <= full_n;
      act_q  <= act_n;
      buf_q  <= buf_n;
      sh_q   <= sh_n;
    end
  end
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic [BYTE_W-1:0] stat_in,
  input  logic              wr_busy,
  output logic              cmd_wen_set,
  output logic              cmd_wen_clr,
  output logic              sr_wr_vld,
  output logic [BYTE_W-1:0] sr_wr_data,
  output logic              wr_byte_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [3:0]        pins_s;
  logic              sck_s, cs_n_s, si_s, hold_n_s;
  logic              sel_start, sel_end, sel_act, bit_fall, byte_done, held;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic              load_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  spi_ee_sync #(
    .W      (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0101)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_in ({spi_sck, spi_cs_n, spi_si, spi_hold_n}),
    .q_out(pins_s)
  );
  assign {sck_s, cs_n_s, si_s, hold_n_s} = pins_s;

  spi_ee_link #(.BYTE_W(BYTE_W)) u_link (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sck_s    (sck_s),
    .cs_n_s   (cs_n_s),
    .si_s     (si_s),
    .hold_n_s (hold_n_s),
    .sel_start(sel_start),
    .sel_end  (sel_end),
    .sel_act  (sel_act),
    .bit_fall (bit_fall),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .bit_cnt  (bit_cnt),
    .held     (held)
  );

  spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .bit_cnt    (bit_cnt),
    .wr_busy    (wr_busy),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .load_stat  (load_stat),
    .cmd_wen_set(cmd_wen_set),
    .cmd_wen_clr(cmd_wen_clr),
    .sr_wr_vld  (sr_wr_vld),
    .sr_wr_data (sr_wr_data),
    .wr_byte_vld(wr_byte_vld),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_commit  (wr_commit)
  );

  spi_ee_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sel_act  (sel_act),
    .held     (held),
    .bit_fall (bit_fall),
    .load_mem (mem_rd_en),
    .load_stat(load_stat),
    .stat_in  (stat_in),
    .mem_rdata(mem_rdata),
    .so       (spi_so),
    .so_oe    (spi_so_oe)
  );
endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_so_oe,
  input logic       held,
  input logic [2:0] bit_cnt,
  input logic       wr_busy,
  input logic       cmd_wen_set,
  input logic       cmd_wen_clr,
  input logic       sr_wr_vld,
  input logic       wr_byte_vld,
  input logic       wr_commit
);
  logic [7:0] cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_cnt <= '0;
    end else if (!spi_cs_n) begin
      cs_hi_cnt <= '0;
    end else if (cs_hi_cnt != 8'hFF) begin
      cs_hi_cnt <= cs_hi_cnt + 8'd1;
    end
  end

  // R1
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_cnt > 8'(SYNC_STAGES + 1)) |-> !spi_so_oe);

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wen_set, cmd_wen_clr, sr_wr_vld, wr_byte_vld, wr_commit}));

  // R6
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !(cmd_wen_set || cmd_wen_clr));

  // R5
  hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> $stable(bit_cnt));

  // R11
  commit_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> spi_cs_n);
endmodule

bind spi_ee_slave spi_ee_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .spi_cs_n   (spi_cs_n),
  .spi_so_oe  (spi_so_oe),
  .held       (held),
  .bit_cnt    (bit_cnt),
  .wr_busy    (wr_busy),
  .cmd_wen_set(cmd_wen_set),
  .cmd_wen_clr(cmd_wen_clr),
  .sr_wr_vld  (sr_wr_vld),
  .wr_byte_vld(wr_byte_vld),
  .wr_commit  (wr_commit)
);

// File: tb/spi_ee_slave_tb_top.sv
module spi_ee_slave_tb_top;
  localparam int HALF = 8;

  logic       clk, rst_n;
  logic       spi_sck, spi_cs_n, spi_si, spi_hold_n;
  logic       spi_so, spi_so_oe;
  logic       mem_rd_en;
  logic [8:0] mem_addr;
  logic [7:0] mem_rdata;
  logic [7:0] stat_in;
  logic       wr_busy;
  logic       cmd_wen_set, cmd_wen_clr, sr_wr_vld, wr_byte_vld, wr_commit;
  logic [7:0] sr_wr_data, wr_data;
  logic [8:0] wr_addr;

  int n_cmp, n_bad;
  int cnt_set, cnt_clr, cnt_sr, cnt_commit;
  logic [7:0] last_sr;
  logic oe_seen;
  logic rd_cap;
  bit   mode3;
  bit   done;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [16:0] wq[$];
  logic [7:0] cap;
  int ncap;

  spi_ee_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .stat_in(stat_in), .wr_busy(wr_busy), .cmd_wen_set(cmd_wen_set),
    .cmd_wen_clr(cmd_wen_clr), .sr_wr_vld(sr_wr_vld), .sr_wr_data(sr_wr_data),
    .wr_byte_vld(wr_byte_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(logic [8:0] a);
    return (a[7:0] * 8'd5 + 8'h3C) ^ {a[8], 7'b0};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= pat(mem_addr);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: SO bytes sampled at the host's rising edge
  always @(posedge spi_sck) begin
    if (rd_cap && spi_hold_n) begin
      cap = {cap[6:0], spi_so_oe ? spi_so : 1'bx};
      ncap++;
      if (ncap == 8) begin
        ncap = 0;
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected SO byte actual=%0h expected=none", cap);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          if (cap !== e) begin
            n_bad++;
            $display("FAIL %s SO byte actual=%0h expected=%0h", t, cap, e);
          end
        end
      end
    end
  end

  // Strobe monitor and write scoreboard
  always @(negedge clk) begin
    if (spi_so_oe) oe_seen = 1'b1;
    if (cmd_wen_set) cnt_set++;
    if (cmd_wen_clr) cnt_clr++;
    if (wr_commit) cnt_commit++;
    if (sr_wr_vld) begin
      cnt_sr++;
      last_sr = sr_wr_data;
    end
    if (wr_byte_vld) begin
      n_cmp++;
      if (wq.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected write actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        automatic logic [16:0] e = wq.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_bad++;
          $display("FAIL R10 write actual=%0h expected=%0h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(logic b);
    spi_sck = 1'b0;
    spi_si  = b;
    wait_clk(HALF);
    spi_sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic sbyte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic frame_begin();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_end();
    if (!mode3) begin
      spi_sck = 1'b0;
      wait_clk(HALF);
    end
    spi_cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic do_read(logic [7:0] op, logic [7:0] a, int n, string tag);
    logic [8:0] full;
    full = {op[3], a};
    frame_begin();
    sbyte(op);
    sbyte(a);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(pat(full + 9'(k)));
      tag_q.push_back(tag);
    end
    rd_cap = 1'b1;
    for (int k = 0; k < n; k++) sbyte(8'hFF);
    rd_cap = 1'b0;
    frame_end();
    chk({tag, " all bytes seen"}, exp_q.size(), 0);
  endtask

  task automatic do_stat(int n, string tag);
    frame_begin();
    sbyte(8'h05);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(stat_in);
      tag_q.push_back(tag);
    end
    rd_cap = 1'b1;
    for (int k = 0; k < n; k++) sbyte(8'h00);
    rd_cap = 1'b0;
    frame_end();
    chk({tag, " status bytes seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; cnt_set = 0; cnt_clr = 0; cnt_sr = 0; cnt_commit = 0;
    last_sr = '0; oe_seen = 1'b0; rd_cap = 1'b0; mode3 = 1'b0; done = 1'b0;
    cap = '0; ncap = 0; mem_rdata = '0;
    spi_sck = 1'b0; spi_cs_n = 1'b1; spi_si = 1'b0; spi_hold_n = 1'b1;
    stat_in = 8'h00; wr_busy = 1'b0;
    rst_n = 1'b0;
    wait_clk(5);
    chk("R1 oe in reset", spi_so_oe, 0);
    chk("R1 rd in reset", mem_rd_en, 0);
    rst_n = 1'b1;
    wait_clk(10);
    chk("R1 oe idle", spi_so_oe, 0);
    chk("R1 strobes idle", cnt_set + cnt_clr + cnt_sr + cnt_commit, 0);

    // R2 plain read, mode 0
    do_read(8'h03, 8'h12, 3, "R2");
    chk("R1 oe after frame", spi_so_oe, 0);
    // R3 upper half and wrap
    do_read(8'h0B, 8'hFE, 4, "R3");
    // R12 mode 3
    spi_sck = 1'b1; mode3 = 1'b1; wait_clk(HALF);
    do_read(8'h03, 8'h80, 2, "R12");
    mode3 = 1'b0; spi_sck = 1'b0; wait_clk(HALF);

    // R7
    frame_begin(); sbyte(8'h06); frame_end();
    chk("R7 set strobe", cnt_set, 1);
    frame_begin(); sbyte(8'h04); frame_end();
    chk("R7 clear strobe", cnt_clr, 1);

    // R8
    stat_in = 8'h82;
    do_stat(2, "R8");

    // R9
    frame_begin(); sbyte(8'h01); sbyte(8'h8C); frame_end();
    chk("R9 status write count", cnt_sr, 1);
    chk("R9 status write data", last_sr, 8'h8C);

    // R10 page write with wrap, upper half
    frame_begin(); sbyte(8'h0A); sbyte(8'hF6);
    for (int k = 0; k < 10; k++) begin
      wq.push_back({9'h1F0 | 9'((6 + k) % 8), 8'(8'h50 + k)});
      sbyte(8'(8'h50 + k));
    end
    frame_end();
    chk("R10 writes seen", wq.size(), 0);
    chk("R11 commit once", cnt_commit, 1);

    // R11 abort mid-byte
    frame_begin(); sbyte(8'h02); sbyte(8'h10);
    wq.push_back({9'h010, 8'h77});
    sbyte(8'h77);
    for (int k = 0; k < 4; k++) sbit(1'b1);
    frame_end();
    chk("R11 no commit on abort", cnt_commit, 1);
    chk("R11 abort write seen", wq.size(), 0);
    do_read(8'h03, 8'h40, 1, "R11");

    // R4 invalid opcode
    oe_seen = 1'b0;
    frame_begin(); sbyte(8'h07); sbyte(8'h03); sbyte(8'h00); frame_end();
    chk("R4 oe stays low", oe_seen, 0);
    chk("R4 no strobes", cnt_set + cnt_clr + cnt_sr + cnt_commit, 1 + 1 + 1 + 1);
    do_read(8'h03, 8'h55, 1, "R4");

    // R6 busy
    wr_busy = 1'b1;
    oe_seen = 1'b0;
    frame_begin(); sbyte(8'h03); sbyte(8'h20); sbyte(8'hFF); frame_end();
    chk("R6 read ignored", oe_seen, 0);
    frame_begin(); sbyte(8'h06); frame_end();
    chk("R6 set ignored", cnt_set, 1);
    stat_in = 8'h83;
    do_stat(1, "R6");
    wr_busy = 1'b0;

    // R5 hold in mid-byte
    frame_begin(); sbyte(8'h03); sbyte(8'h20);
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(pat(9'h020 + 9'(k)));
      tag_q.push_back("R5");
    end
    rd_cap = 1'b1;
    sbyte(8'hFF);
    for (int k = 0; k < 3; k++) sbit(1'b1);
    spi_sck = 1'b0; wait_clk(HALF);
    spi_hold_n = 1'b0; wait_clk(2 * HALF);
    chk("R5 oe low while held", spi_so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      spi_sck = 1'b1; wait_clk(HALF);
      spi_sck = 1'b0; wait_clk(HALF);
    end
    chk("R5 oe low after toggles", spi_so_oe, 0);
    spi_hold_n = 1'b1; wait_clk(HALF);
    for (int k = 0; k < 5; k++) sbit(1'b1);
    sbyte(8'hFF);
    rd_cap = 1'b0;
    frame_end();
    chk("R5 bytes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule